// File: doc/BRIEF.md
# I2C Bus Recovery Sequence Generator

This block brings a downstream I2C segment that may be stuck mid-transfer back to a known idle state. A one-cycle start request makes the block take both lines. It then toggles SCL nine times while leaving SDA released, which is the same as eight data bits followed by a not-acknowledge. A slave that was transmitting when the bus was abandoned therefore sees its read end and lets go of SDA. The block then forms a STOP condition, reports completion with a one-cycle done pulse, and releases both lines.

The open-drain lines are modelled as pull-low enables: a 1 on an output means that line is driven low, and a 0 means it is released so the pull-up takes it high. The block never samples the bus. It issues the same fixed train every time it is asked, whether or not the segment looked idle. The SCL period comes from a parameter giving the length of one half period in system clocks. The controlling logic uses done to decide when a new master may be connected.

Top module: `busrec_gen`

## Requirements
- R1: Out of reset, both pull-low enables are 0, busy is 0 and done is 0.
- R2: A start sampled high while idle makes busy 1 on the next cycle, with SCL pulled low and SDA released in that same cycle.
- R3: The sequence opens with exactly nine SCL pulses. Each pulse is SCL pulled low for HALF_DIV system clocks, then released for HALF_DIV system clocks. SDA stays released for all eighteen of these phases.
- R4: Directly after the ninth released-SCL phase, a STOP is formed in three phases of HALF_DIV clocks each, in this order: both lines pulled low; SCL released with SDA still low; both lines released. SDA is pulled low for exactly 2*HALF_DIV clocks per sequence, and it is only ever released while SCL is released.
- R5: The cycle after the last STOP phase carries done = 1 for exactly one cycle, with both lines released and busy still 1. On the following cycle the block is idle again with busy = 0 and done = 0.
- R6: A start that arrives while busy is 1, including during the done cycle, is ignored. The waveform and the done timing stay exactly as if it had not arrived.
- R7: HALF_DIV sets every phase length. A run takes 21*HALF_DIV + 1 busy cycles for any HALF_DIV of 1 or more, and done is only ever high while busy is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request to run the recovery sequence |
| scl_pull_o | output | 1 | 1 = pull downstream SCL low |
| sda_pull_o | output | 1 | 1 = pull downstream SDA low |
| busy_o | output | 1 | High from the cycle after an accepted start through the done cycle |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
Every cycle of a run is compared against a waveform computed from the phase rules, on two instances with different half-period settings. An off-by-one in the divider or in the pulse counter, such as eight or ten pulses or a phase one clock short, therefore shows up as a mismatch and as a wrong pulse count. The bench counts SDA-low cycles and SCL release edges that occur while SDA is released. An SDA that dips during the clock train, or a STOP with its phases in the wrong order, breaks these counts or the waveform. Start requests are injected in the middle of a run and exactly on the done cycle. A design that restarts, stretches busy or repeats the done pulse in response is caught.

// File: rtl/busrec_pkg.sv
package busrec_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SCL_LO,
    ST_SCL_HI,
    ST_STOP_SETUP,
    ST_STOP_HOLD,
    ST_STOP_FREE,
    ST_DONE
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic runDiv;     // half-period divider counts
    logic clrDiv;     // restart divider at zero
    logic clrPulse;   // clear pulse counter
    logic incPulse;   // one SCL pulse completed
    logic loadLines;  // load line enables below
    logic sclLow;
    logic sdaLow;
  } seqStrobe_t;

endpackage

// File: rtl/busrec_datapath.sv
module busrec_datapath
  import busrec_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int NUM_PULSES = 9
) (
  input  logic       clk,
  input  logic       rst_n,
  input  seqStrobe_t stb,
  output logic       phaseTick,
  output logic       lastPulse,
  output logic       sclLowQ,
  output logic       sdaLowQ
);

  localparam int DIV_W  = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam int PCNT_W = $clog2(NUM_PULSES + 1);
  localparam logic [DIV_W-1:0]  DIV_LAST   = DIV_W'(HALF_DIV - 1);
  localparam logic [PCNT_W-1:0] PULSE_LAST = PCNT_W'(NUM_PULSES);

  logic [DIV_W-1:0]  divCnt;
  logic [PCNT_W-1:0] pulseCnt;

  assign phaseTick = stb.runDiv && (divCnt == DIV_LAST);
  assign lastPulse = (pulseCnt == PULSE_LAST);

  // Half-period divider
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      divCnt <= '0;
    end else if (stb.clrDiv || phaseTick) begin
      divCnt <= '0;
    end else if (stb.runDiv) begin
      divCnt <= divCnt + 1'b1;
    end
  end

  // Completed SCL pulse counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pulseCnt <= '0;
    end else if (stb.clrPulse) begin
      pulseCnt <= '0;
    end else if (stb.incPulse) begin
      pulseCnt <= pulseCnt + 1'b1;
    end
  end

  // Open-drain pull-low enables
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclLowQ <= 1'b0;
      sdaLowQ <= 1'b0;
    end else if (stb.loadLines) begin
      sclLowQ <= stb.sclLow;
      sdaLowQ <= stb.sdaLow;
    end
  end

  AST_DIV_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= DIV_LAST); // R7

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    pulseCnt <= PULSE_LAST); // R3

  AST_SDA_FREE_IN_TRAIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pulseCnt < PULSE_LAST) |-> !sdaLowQ); // R3

  AST_SDA_RISE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sdaLowQ) |-> !sclLowQ); // R4

endmodule

// File: rtl/busrec_ctrl.sv
module busrec_ctrl
  import busrec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       phaseTick,
  input  logic       lastPulse,
  output seqStrobe_t stb,
  output logic       busy,
  output logic       done
);

  seqState_t state, stateNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= stateNext;
  end

  always_comb begin
    stateNext = state;
    stb       = '0;
    stb.runDiv = (state != ST_IDLE) && (state != ST_DONE);
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          stateNext     = ST_SCL_LO;
          stb.clrDiv    = 1'b1;
          stb.clrPulse  = 1'b1;
          stb.loadLines = 1'b1;
          stb.sclLow    = 1'b1;
        end
      end
      ST_SCL_LO: begin
        if (phaseTick) begin
          stateNext     = ST_SCL_HI;
          stb.incPulse  = 1'b1;
          stb.loadLines = 1'b1;
        end
      end
      ST_SCL_HI: begin
        if (phaseTick) begin
          stb.loadLines = 1'b1;
          stb.sclLow    = 1'b1;
          if (lastPulse) begin
            stateNext  = ST_STOP_SETUP;
            stb.sdaLow = 1'b1;
          end else begin
            stateNext  = ST_SCL_LO;
          end
        end
      end
      ST_STOP_SETUP: begin
        if (phaseTick) begin
          stateNext     = ST_STOP_HOLD;
          stb.loadLines = 1'b1;
          stb.sdaLow    = 1'b1;
        end
      end
      ST_STOP_HOLD: begin
        if (phaseTick) begin
          stateNext     = ST_STOP_FREE;
          stb.loadLines = 1'b1;
        end
      end
      ST_STOP_FREE: begin
        if (phaseTick) stateNext = ST_DONE;
      end
      ST_DONE: begin
        stateNext = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  assign busy = (state != ST_IDLE);
  assign done = (state == ST_DONE);

  AST_DONE_IMPLIES_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R7

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && !busy)); // R5

  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> busy); // R6

  AST_START_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && startReq) |=> (busy && !done)); // R2

endmodule

// File: rtl/busrec_gen.sv
module busrec_gen
  import busrec_pkg::*;
#(
  parameter int HALF_DIV   = 4,
  parameter int NUM_PULSES = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic scl_pull_o,
  output logic sda_pull_o,
  output logic busy_o,
  output logic done_o
);

  seqStrobe_t stb;
  logic       phaseTick;
  logic       lastPulse;

  busrec_ctrl ctrl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .startReq  (start_i),
    .phaseTick (phaseTick),
    .lastPulse (lastPulse),
    .stb       (stb),
    .busy      (busy_o),
    .done      (done_o)
  );

  busrec_datapath #(
    .HALF_DIV   (HALF_DIV),
    .NUM_PULSES (NUM_PULSES)
  ) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .stb       (stb),
    .phaseTick (phaseTick),
    .lastPulse (lastPulse),
    .sclLowQ   (scl_pull_o),
    .sdaLowQ   (sda_pull_o)
  );

  AST_LINES_FREE_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!scl_pull_o && !sda_pull_o)); // R5

  AST_IDLE_LINES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (!scl_pull_o && !sda_pull_o)); // R1

endmodule

// File: tb/busrec_gen_tb_top.sv
module busrec_gen_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int HA = 4;
  localparam int HB = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startA = 1'b0, startB = 1'b0;
  logic sclA, sdaA, busyA, doneA;
  logic sclB, sdaB, busyB, doneB;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  busrec_gen #(.HALF_DIV(HA)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(startA),
    .scl_pull_o(sclA), .sda_pull_o(sdaA), .busy_o(busyA), .done_o(doneA));

  busrec_gen #(.HALF_DIV(HB)) dut_fast_i (
    .clk(clk), .rst_n(rst_n), .start_i(startB),
    .scl_pull_o(sclB), .sda_pull_o(sdaB), .busy_o(busyB), .done_o(doneB));

  // Expected {busy, done, sclPull, sdaPull} at cycle i after the start edge
  function automatic logic [3:0] expWave(int h, int i);
    int p;
    if (i < 21*h) begin
      p = i / h;
      if (p < 18)       return {2'b10, (p % 2 == 0), 1'b0};
      else if (p == 18) return 4'b1011;
      else if (p == 19) return 4'b1001;
      else              return 4'b1000;
    end else if (i == 21*h) begin
      return 4'b1100;
    end
    return 4'b0000;
  endfunction

  function automatic string reqOf(int h, int i);
    if (i == 0)          return "R2";
    else if (i < 18*h)   return "R3";
    else if (i < 21*h)   return "R4";
    else if (i == 21*h)  return "R5";
    return "R6";
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // One full run on both instances; injA/injB give a cycle index at which
  // a stray start is raised (-1 for none)
  task automatic runSeq(input string name, input int injA, input int injB);
    int total;
    int badA, badB, badIdxA, badIdxB;
    logic [3:0] gotA, gotB, firstGotA, firstGotB;
    int risesA, risesB, sdaCntA, sdaCntB, busyCntA, busyCntB;
    logic prevSclA, prevSclB;
    total = 21*HA + 4;
    badA = 0; badB = 0; badIdxA = 0; badIdxB = 0;
    firstGotA = '0; firstGotB = '0;
    risesA = 0; risesB = 0; sdaCntA = 0; sdaCntB = 0;
    busyCntA = 0; busyCntB = 0;
    prevSclA = 1'b0; prevSclB = 1'b0;
    @(negedge clk);
    startA = 1'b1; startB = 1'b1;
    for (int i = 0; i < total; i++) begin
      @(negedge clk);
      gotA = {busyA, doneA, sclA, sdaA};
      gotB = {busyB, doneB, sclB, sdaB};
      if (gotA !== expWave(HA, i)) begin
        if (badA == 0) begin badIdxA = i; firstGotA = gotA; end
        badA++;
      end
      if (gotB !== expWave(HB, i)) begin
        if (badB == 0) begin badIdxB = i; firstGotB = gotB; end
        badB++;
      end
      if (prevSclA && !sclA && !sdaA) risesA++;
      if (prevSclB && !sclB && !sdaB) risesB++;
      if (sdaA) sdaCntA++;
      if (sdaB) sdaCntB++;
      if (busyA) busyCntA++;
      if (busyB) busyCntB++;
      prevSclA = sclA; prevSclB = sclB;
      startA = (i == injA);
      startB = (i == injB);
    end
    startA = 1'b0; startB = 1'b0;
    check(badA == 0, (badA == 0) ? "R3" : reqOf(HA, badIdxA),
          $sformatf("%s waveform HALF_DIV=%0d cycle %0d", name, HA, badIdxA),
          firstGotA, expWave(HA, badIdxA));
    check(badB == 0, (badB == 0) ? "R7" : reqOf(HB, badIdxB),
          $sformatf("%s waveform HALF_DIV=%0d cycle %0d", name, HB, badIdxB),
          firstGotB, expWave(HB, badIdxB));
    check(risesA == 9, "R3", {name, " SCL pulses A"}, risesA, 9);
    check(risesB == 9, "R3", {name, " SCL pulses B"}, risesB, 9);
    check(sdaCntA == 2*HA, "R4", {name, " SDA low cycles A"}, sdaCntA, 2*HA);
    check(sdaCntB == 2*HB, "R4", {name, " SDA low cycles B"}, sdaCntB, 2*HB);
    check(busyCntA == 21*HA+1, "R7", {name, " busy length A"}, busyCntA, 21*HA+1);
    check(busyCntB == 21*HB+1, "R7", {name, " busy length B"}, busyCntB, 21*HB+1);
  endtask

  task automatic testReset();
    @(negedge clk);
    check(sclA == 1'b0 && sclB == 1'b0, "R1", "SCL pull after reset", sclA, 0);
    check(sdaA == 1'b0 && sdaB == 1'b0, "R1", "SDA pull after reset", sdaA, 0);
    check(busyA == 1'b0 && busyB == 1'b0, "R1", "busy after reset", busyA, 0);
    check(doneA == 1'b0 && doneB == 1'b0, "R1", "done after reset", doneA, 0);
  endtask

  task automatic testBasic();
    runSeq("basic", -1, -1);        // R2 R3 R4 R5 R7
  endtask

  task automatic testStartMidRun();
    runSeq("mid-run start", 10, 7); // R6
  endtask

  task automatic testStartOnDone();
    runSeq("start on done", 21*HA, 21*HB); // R6: stray start in done cycle
    repeat (2) @(negedge clk);
    check(!busyA && !busyB, "R6", "idle after start on done", busyA, 0);
  endtask

  task automatic testBackToBack();
    runSeq("back-to-back", -1, -1); // R2 restart right after idle
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testBasic();
    testStartMidRun();
    testStartOnDone();
    testBackToBack();
    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule